// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point words and returns a normalized product, rounded to nearest with ties to even, two clock cycles later. Each word carries a sign in bit 31, a biased exponent in bits 30..23 (bias 127) and a fraction in bits 22..0. The fraction has a hidden leading one whenever the exponent code lies between 1 and 254.

The first pipeline stage classifies both operands, settles every special-operand case, forms the result sign and the combined exponent, and multiplies the 24-bit significands. The second stage normalizes the 48-bit product, rounds it using guard, round and sticky bits, renormalizes when rounding carries out, and packs the result.

Results whose exponent leaves the normal range saturate. Results too large become a signed infinity and raise an overflow flag. Results too small are flushed to a signed zero and raise an underflow flag. A new operand pair can be accepted on every cycle.

Top module: `fpmul_top`

## Requirements
- R1: `out_valid` is `in_valid` delayed by exactly two clock cycles, and a new operand pair is accepted every cycle.
- R2: When both operands have exponent codes from 1 to 254, the result sign bit (bit 31) equals the XOR of the two operand sign bits.
- R3: For two normal operands, the result exponent is ea + eb - 127. It is one higher when the product of the significands (each with its hidden one) is 2 or more, and that product is then shifted right by one.
- R4: Rounding is to nearest. Bits below the kept 24-bit significand are reduced to a guard bit, a round bit and a sticky bit (the OR of all lower bits). An exact halfway case rounds to the even significand.
- R5: When rounding carries out of the significand, the significand is shifted right once more and the exponent is incremented.
- R6: If the final exponent is above 254, the result is 0x7F800000 with the computed sign, `out_ovf` is 1 and `out_unf` is 0.
- R7: If the final exponent is below 1, the result is all zeros apart from the computed sign, `out_unf` is 1 and `out_ovf` is 0.
- R8: An operand with exponent code 255 and a nonzero fraction (NaN) yields 0x7FC00000 with both flags at 0.
- R9: Infinity (exponent 255, fraction 0) times a zero operand yields 0x7FC00000 with both flags at 0.
- R10: Infinity times a normal operand or another infinity yields infinity with the XOR sign and both flags at 0.
- R11: An operand with exponent code 0 counts as zero whatever its fraction. Multiplied by a normal operand or by zero, it yields a zero carrying the XOR sign, with both flags at 0.
- R12: During and after reset, `out_valid`, `out_ovf`, `out_unf` and `out_result` are 0. Both flags are 0 in every cycle where `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | 32 | First operand word |
| in_b | input | 32 | Second operand word |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | 32 | Product word |
| out_ovf | output | 1 | Result saturated to infinity |
| out_unf | output | 1 | Result flushed to zero |

## Verification
The directed cases target five points where a design can go wrong:
- **Halfway ties with odd and with even kept significands.** A design that always rounds halves up is off by one unit in the last place on the even case.
- **A product that rounds up from all-ones into the next power of two.** Missing renormalization returns 1.0 times the old exponent instead of 2.0.
- **Exponent sums just beyond 254 and just below 1, with both signs.** Wrong saturation returns wrapped exponents, or drops the sign.
- **Infinity against zero and against denormal encodings.** A wrong decode returns infinity instead of the canonical NaN.
- **NaN propagation.**

Random operands, weighted toward normal exponents, are compared against a bench model. That model rounds by comparing the discarded remainder with half an ulp, not by guard/round/sticky logic.

// File: rtl/fpm_pkg.sv
// Package: shared operand class encoding for the floating-point multiplier.
// Assumes: classes are decided from exponent and fraction alone.
package fpm_pkg;
    typedef enum logic [1:0] {
        CLS_NORM = 2'd0,
        CLS_ZERO = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } fp_cls_t;
endpackage

// File: rtl/fpm_unpack.sv
// Module: splits one operand word into sign, exponent and significand with
// hidden bit, and classifies it.
// Assumes: exponent code 0 is treated as zero (denormal inputs are flushed).
module fpm_unpack #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] op,
    output logic                  sign,
    output logic [EXP_W-1:0]      exp,
    output logic [FRAC_W:0]       sig,
    output fpm_pkg::fp_cls_t      cls
);
    localparam int W = 1 + EXP_W + FRAC_W;

    logic [FRAC_W-1:0] frac;

    // Field split and class decode from the exponent code extremes.
    always_comb begin
        sign = op[W-1];
        exp  = op[W-2 -: EXP_W];
        frac = op[FRAC_W-1:0];
        if (exp == '0)
            cls = fpm_pkg::CLS_ZERO;
        else if (exp == '1)
            cls = (frac == '0) ? fpm_pkg::CLS_INF : fpm_pkg::CLS_NAN;
        else
            cls = fpm_pkg::CLS_NORM;
        sig = {cls == fpm_pkg::CLS_NORM, frac};
    end
endmodule

// File: rtl/fpm_special.sv
// Module: resolves the result when either operand is zero, infinity or NaN.
// Assumes: sign is already the XOR of the operand signs.
module fpm_special #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  fpm_pkg::fp_cls_t      cls_a,
    input  fpm_pkg::fp_cls_t      cls_b,
    input  logic                  sign,
    output logic                  hit,
    output logic [EXP_W+FRAC_W:0] word
);
    import fpm_pkg::*;

    localparam logic [EXP_W+FRAC_W:0] QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic any_nan, any_inf, any_zero;

    // Priority: NaN, then infinity times zero, then infinity, then zero.
    always_comb begin
        any_nan  = (cls_a == CLS_NAN)  || (cls_b == CLS_NAN);
        any_inf  = (cls_a == CLS_INF)  || (cls_b == CLS_INF);
        any_zero = (cls_a == CLS_ZERO) || (cls_b == CLS_ZERO);
        hit      = any_nan || any_inf || any_zero;
        if (any_nan || (any_inf && any_zero))
            word = QNAN;
        else if (any_inf)
            word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else
            word = {sign, {(EXP_W+FRAC_W){1'b0}}};
    end
endmodule

// File: rtl/fpm_round.sv
// Module: normalizes the raw significand product, rounds to nearest-even,
// renormalizes on carry-out and packs the word with range flags.
// Assumes: prod is the product of two significands with hidden one set,
// so its top bit or the one below it is 1.
module fpm_round #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                    sign,
    input  logic signed [EXP_W+1:0] exp_in,
    input  logic [2*FRAC_W+1:0]     prod,
    output logic [EXP_W+FRAC_W:0]   word,
    output logic                    ovf,
    output logic                    unf
);
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int XE_W   = EXP_W + 2;
    localparam int EMAX   = (1 << EXP_W) - 2;

    logic                   top;
    logic [SIG_W-1:0]       kept;
    logic                   guard_b, round_b, sticky_b, inc;
    logic [SIG_W:0]         sum;
    logic                   carry;
    logic [SIG_W-1:0]       fin_sig;
    logic signed [XE_W-1:0] exp_f;

    // Select the kept window and the guard, round and sticky bits.
    always_comb begin
        top = prod[PROD_W-1];
        if (top) begin
            kept     = prod[PROD_W-1 -: SIG_W];
            guard_b  = prod[PROD_W-1-SIG_W];
            round_b  = prod[PROD_W-2-SIG_W];
            sticky_b = |prod[PROD_W-3-SIG_W:0];
        end else begin
            kept     = prod[PROD_W-2 -: SIG_W];
            guard_b  = prod[PROD_W-2-SIG_W];
            round_b  = prod[PROD_W-3-SIG_W];
            sticky_b = |prod[PROD_W-4-SIG_W:0];
        end
    end

    // Round to nearest-even, renormalize on carry-out, then range check and pack.
    always_comb begin
        inc     = guard_b & (round_b | sticky_b | kept[0]);
        sum     = {1'b0, kept} + {{SIG_W{1'b0}}, inc};
        carry   = sum[SIG_W];
        fin_sig = carry ? sum[SIG_W:1] : sum[SIG_W-1:0];
        exp_f   = exp_in + $signed({{(XE_W-1){1'b0}}, top})
                         + $signed({{(XE_W-1){1'b0}}, carry});
        ovf     = exp_f > $signed(XE_W'(EMAX));
        unf     = exp_f < $signed(XE_W'(1));
        if (ovf)
            word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else if (unf)
            word = {sign, {(EXP_W+FRAC_W){1'b0}}};
        else
            word = {sign, exp_f[EXP_W-1:0], fin_sig[FRAC_W-1:0]};
    end
endmodule

// File: rtl/fpmul_top.sv
// Module: two-stage pipelined single-precision multiplier.
// Stage 1 decodes, resolves special operands, sums exponents, multiplies significands.
// Stage 2 rounds and registers the result with overflow/underflow flags.
// Assumes: synchronous active-low reset; one operand pair per cycle at most.
module fpmul_top #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [EXP_W+FRAC_W:0]   in_a,
    input  logic [EXP_W+FRAC_W:0]   in_b,
    output logic                    out_valid,
    output logic [EXP_W+FRAC_W:0]   out_result,
    output logic                    out_ovf,
    output logic                    out_unf
);
    localparam int W      = 1 + EXP_W + FRAC_W;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * SIG_W;
    localparam int XE_W   = EXP_W + 2;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;

    logic [1:0]             op_sign;
    logic [EXP_W-1:0]       op_exp [2];
    logic [SIG_W-1:0]       op_sig [2];
    fpm_pkg::fp_cls_t       op_cls [2];

    genvar gi;
    generate
        for (gi = 0; gi < 2; gi++) begin : g_unp
            fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp (
                .op   ((gi == 0) ? in_a : in_b),
                .sign (op_sign[gi]),
                .exp  (op_exp[gi]),
                .sig  (op_sig[gi]),
                .cls  (op_cls[gi])
            );
        end
    endgenerate

    logic             res_sign;
    logic             spec_hit;
    logic [W-1:0]     spec_word;
    logic signed [XE_W-1:0] exp_sum;

    assign res_sign = op_sign[0] ^ op_sign[1];

    fpm_special #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_spec (
        .cls_a (op_cls[0]),
        .cls_b (op_cls[1]),
        .sign  (res_sign),
        .hit   (spec_hit),
        .word  (spec_word)
    );

    // Biased exponent recombination: subtract one bias from the sum.
    assign exp_sum = $signed({2'b00, op_exp[0]}) + $signed({2'b00, op_exp[1]})
                   - $signed(XE_W'(BIAS));

    logic                   s1_valid, s1_special, s1_sign;
    logic [W-1:0]           s1_spec;
    logic signed [XE_W-1:0] s1_exp;
    logic [PROD_W-1:0]      s1_prod;

    // Stage 1 register: decoded operands and raw significand product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid   <= 1'b0;
            s1_special <= 1'b0;
            s1_sign    <= 1'b0;
            s1_spec    <= '0;
            s1_exp     <= '0;
            s1_prod    <= '0;
        end else begin
            s1_valid   <= in_valid;
            s1_special <= spec_hit;
            s1_sign    <= res_sign;
            s1_spec    <= spec_word;
            s1_exp     <= exp_sum;
            s1_prod    <= PROD_W'(op_sig[0]) * PROD_W'(op_sig[1]);
        end
    end

    logic [W-1:0] rnd_word;
    logic         rnd_ovf, rnd_unf;

    fpm_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_rnd (
        .sign   (s1_sign),
        .exp_in (s1_exp),
        .prod   (s1_prod),
        .word   (rnd_word),
        .ovf    (rnd_ovf),
        .unf    (rnd_unf)
    );

    // Stage 2 register: pick special or rounded result; flags only with valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_ovf    <= 1'b0;
            out_unf    <= 1'b0;
        end else begin
            out_valid  <= s1_valid;
            out_result <= s1_special ? s1_spec : rnd_word;
            out_ovf    <= s1_valid & ~s1_special & rnd_ovf;
            out_unf    <= s1_valid & ~s1_special & rnd_unf;
        end
    end

    localparam logic [W-1:0] QNAN_W = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    assert_lat_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);
    assert_bubble_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##1 !out_valid);
    assert_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_a[W-2 -: EXP_W] != '0 && in_a[W-2 -: EXP_W] != '1 &&
         in_b[W-2 -: EXP_W] != '0 && in_b[W-2 -: EXP_W] != '1)
        |=> ##1 (out_result[W-1] == $past(in_a[W-1] ^ in_b[W-1], 2)));
    assert_ovf_inf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ovf) |-> (out_result[W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));
    assert_flag_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_ovf && out_unf));
    assert_unf_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_unf) |-> (out_result[W-2:0] == '0));
    assert_nan_canon_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_result[W-2 -: EXP_W] == '1 && out_result[FRAC_W-1:0] != '0)
        |-> (out_result == QNAN_W && !out_ovf && !out_unf));
    assert_idle_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_ovf && !out_unf));
endmodule

// File: tb/fpmul_top_tb.sv
`timescale 1ns/1ps
module fpmul_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_ovf, out_unf;

    int nvec  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    fpmul_top u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_result(out_result),
        .out_ovf(out_ovf), .out_unf(out_unf)
    );

    // Reference: returns {ovf, unf, word}; rounding by remainder versus half-ulp.
    function automatic logic [33:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
        logic [7:0]  ea, eb;
        logic [22:0] fa, fb;
        logic        s;
        logic [63:0] p, kept, rem, half;
        int          sh, e;
        ea = a[30:23]; eb = b[30:23]; fa = a[22:0]; fb = b[22:0];
        s  = a[31] ^ b[31];
        if ((ea == 8'hFF && fa != 0) || (eb == 8'hFF && fb != 0))
            return {2'b00, 32'h7FC00000};
        if ((ea == 8'hFF && eb == 8'h00) || (eb == 8'hFF && ea == 8'h00))
            return {2'b00, 32'h7FC00000};
        if (ea == 8'hFF || eb == 8'hFF)
            return {2'b00, s, 8'hFF, 23'd0};
        if (ea == 8'h00 || eb == 8'h00)
            return {2'b00, s, 31'd0};
        p    = {40'd0, 1'b1, fa} * {40'd0, 1'b1, fb};
        sh   = p[47] ? 24 : 23;
        e    = int'(ea) + int'(eb) - 127 + (p[47] ? 1 : 0);
        kept = p >> sh;
        rem  = p - (kept << sh);
        half = 64'd1 << (sh - 1);
        if (rem > half || (rem == half && kept[0])) kept = kept + 1;
        if (kept == (64'd1 << 24)) begin
            kept = kept >> 1;
            e    = e + 1;
        end
        if (e > 254) return {2'b10, s, 8'hFF, 23'd0};
        if (e < 1)   return {2'b01, s, 31'd0};
        return {2'b00, s, e[7:0], kept[22:0]};
    endfunction

    task automatic chk(input string req, input logic [34:0] got, input logic [34:0] exp);
        nvec++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    // Single operation with idle cycle, result sampled two negedges later.
    task automatic run_one(input logic [31:0] a, input logic [31:0] b,
                           input logic [33:0] exp, input string req);
        @(negedge clk);
        in_a = a; in_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk(req, {out_valid, out_ovf, out_unf, out_result}, {1'b1, exp});
    endtask

    function automatic logic [31:0] rnd_op();
        logic [7:0] e;
        logic [31:0] r;
        r = $urandom;
        case ($urandom % 10)
            0:       e = ($urandom % 2 == 0) ? 8'h00 : 8'hFF;
            1:       e = 8'(($urandom % 8) + 1);
            2:       e = 8'(254 - ($urandom % 8));
            default: e = 8'(($urandom % 254) + 1);
        endcase
        if ($urandom % 8 == 0) r[22:0] = 23'(r[3:0]);
        return {r[31], e, r[22:0]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] sa [3];
        logic [31:0] sb [3];
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R12: reset state
        chk("R12 reset", {out_valid, out_ovf, out_unf, out_result}, 35'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 idle after reset", {out_valid, out_ovf, out_unf, out_result}, 35'd0);

        // R3: exponent recombination and normalization
        run_one(32'h3F800000, 32'h3F800000, {2'b00, 32'h3F800000}, "R3 1*1");
        run_one(32'h40000000, 32'h40400000, {2'b00, 32'h40C00000}, "R3 2*3 renorm");
        run_one(32'h50000000, 32'h30000000, {2'b00, 32'h40800000}, "R3 exp sum");
        // R2: sign XOR
        run_one(32'hBFC00000, 32'h40000000, {2'b00, 32'hC0400000}, "R2 neg*pos");
        run_one(32'hBFC00000, 32'hC0000000, {2'b00, 32'h40400000}, "R2 neg*neg");
        // R4: ties to even
        run_one(32'h3F800001, 32'h3FC00000, {2'b00, 32'h3FC00002}, "R4 tie odd up");
        run_one(32'h3F800003, 32'h3FC00000, {2'b00, 32'h3FC00004}, "R4 tie even stay");
        // R5: rounding carry-out
        run_one(32'h3FFFFFFE, 32'h3F800001, {2'b00, 32'h40000000}, "R5 carry renorm");
        // R6 / R7: range
        run_one(32'h7F000000, 32'h40000000, {2'b10, 32'h7F800000}, "R6 overflow pos");
        run_one(32'hFF000000, 32'h40000000, {2'b10, 32'hFF800000}, "R6 overflow neg");
        run_one(32'h00800000, 32'h3F000000, {2'b01, 32'h00000000}, "R7 underflow pos");
        run_one(32'h80800000, 32'h3F000000, {2'b01, 32'h80000000}, "R7 underflow neg");
        // R8..R11: special operands
        run_one(32'h7FC00001, 32'h3F800000, {2'b00, 32'h7FC00000}, "R8 NaN in");
        run_one(32'h7F800000, 32'hFF800001, {2'b00, 32'h7FC00000}, "R8 NaN*inf");
        run_one(32'h7F800000, 32'h80000000, {2'b00, 32'h7FC00000}, "R9 inf*zero");
        run_one(32'h00000001, 32'hFF800000, {2'b00, 32'h7FC00000}, "R9 denorm*inf");
        run_one(32'hFF800000, 32'h40000000, {2'b00, 32'hFF800000}, "R10 inf*2");
        run_one(32'h7F800000, 32'hFF800000, {2'b00, 32'hFF800000}, "R10 inf*inf");
        run_one(32'h80000000, 32'h40A00000, {2'b00, 32'h80000000}, "R11 -0*5");
        run_one(32'h00000001, 32'h3F800000, {2'b00, 32'h00000000}, "R11 denorm flush");

        // R1: back-to-back issue, then bubble
        sa[0] = 32'h40000000; sb[0] = 32'h40400000;
        sa[1] = 32'h7F000000; sb[1] = 32'h40000000;
        sa[2] = 32'hBF800000; sb[2] = 32'h3F800001;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (k >= 2 && k <= 4)
                chk("R1 stream", {out_valid, out_ovf, out_unf, out_result},
                    {1'b1, ref_mul(sa[k-2], sb[k-2])});
            if (k == 5)
                chk("R1 bubble R12", {out_valid, out_ovf, out_unf}, 3'b000);
            if (k < 3) begin
                in_a = sa[k]; in_b = sb[k]; in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
        end

        // Random mix across R2..R11 against the reference model
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ra, rb;
            ra = rnd_op();
            rb = rnd_op();
            run_one(ra, rb, ref_mul(ra, rb), "R2-R11 random");
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule